// File: doc/BRIEF.md
# Filtered Pin Edge Detector

This block conditions one external timer pin before a counter or capture unit sees it. The pin first passes a two-flop synchronizer. A filter then samples the synchronized level and takes a new level only when that level has appeared on two samples in a row, so a short glitch never reaches the filtered level. A select input sets the sampling rate. When the pin serves as the count clock, the filter samples on every system clock. When the pin serves as a capture trigger, the filter samples only on an external prescaled tick.

When the filter takes a new level, the block reports it as a single-cycle event pulse, but only if the two-bit edge mode asks for that direction. The filtered level is also an output. The filtered level starts low after reset, so a pin held high at the first enable produces one rising event. After a stop, the first sample on re-enable loads the level without an event, so a pin held high at that point reports nothing. While the enable is low, sampling stops and the filtered level is held.

Top module: `pin_edge_filter`

## Requirements
- R1: The filtered level changes only after two consecutive samples of the synchronized pin both show the new level. A pulse seen on a single sample is discarded.
- R2: With `fast_sel` = 1, the filter takes one sample on every system clock.
- R3: With `fast_sel` = 0, the filter samples only in cycles where `tick_i` is high. A pulse that covers fewer than two ticks leaves the level and the event output unchanged.
- R4: `edge_sel` encoding: 00 reports only falling changes (1 to 0), 01 reports only rising changes (0 to 1), 10 reports both directions.
- R5: With `edge_sel` = 11, no event is reported, but `level_o` still follows the filtered pin.
- R6: In fast mode with enable high, a pin change applied before clock edge k shows on `level_o` after edge k+3. Any reported event on `edge_o` appears in that same cycle.
- R7: `edge_o` is high for exactly one system clock cycle per accepted change.
- R8: While `en` is low, no sample is taken, `level_o` holds its value and `edge_o` stays low.
- R9: After reset, `level_o` is 0. If the pin is high at the first enable and 01 or 10 is selected, exactly one rising event is reported.
- R10: On each re-enable after a stop, the first sample loads the level directly with no event. A pin high at re-enable therefore yields no rising event and `level_o` becomes 1.
- R11: While `rst` is high and in the cycle after it, `level_o` and `edge_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low stops sampling |
| fast_sel | input | 1 | 1: sample every clock (count-clock use); 0: sample on tick_i (capture use) |
| tick_i | input | 1 | Prescaled sampling tick, one cycle wide |
| edge_sel | input | 2 | Event direction: 00 fall, 01 rise, 10 both, 11 none |
| pin_i | input | 1 | Asynchronous external pin |
| edge_o | output | 1 | One-cycle event pulse for an accepted change |
| level_o | output | 1 | Filtered pin level |

## Verification
The assertions assume that `edge_sel`, `fast_sel` and `en` are driven synchronously to `clk`. They also assume that `tick_i` is a plain level that the filter reads only when `fast_sel` is low. None of them makes any assumption about the pin. The stimulus changes every input half a period away from the active edge and holds `edge_sel` steady around each accepted change. The stimulus produces ticks on every fourth cycle, so every pulse length in tick mode falls clearly below or above the two-tick limit. A behavioural model in the bench, built from a delay queue and sample history, predicts `level_o` and `edge_o` on every cycle.

// File: rtl/pef_pkg.sv
package pef_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_t;

  function automatic logic mode_wants_rise(input edge_mode_t m);
    return (m == EDGE_RISE) || (m == EDGE_BOTH);
  endfunction

  function automatic logic mode_wants_fall(input edge_mode_t m);
    return (m == EDGE_FALL) || (m == EDGE_BOTH);
  endfunction

endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/pef_filter.sv
module pef_filter #(
  parameter int SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fast_sel,
  input  logic tick_i,
  input  logic din,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HW = SAMPLES - 1;

  logic [HW-1:0] hist_q;
  logic [HW:0]   hist_cat;
  logic          lvl_q;
  logic          primed_q;
  logic          resync_q;
  logic          smp_en;
  logic          agree;
  logic          accept;

  assign smp_en   = en & (fast_sel | tick_i);
  assign hist_cat = {hist_q, din};
  assign agree    = din ? (&hist_q) : ~(|hist_q);
  assign accept   = smp_en & ~resync_q & agree & (din != lvl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q   <= '0;
      lvl_q    <= 1'b0;
      primed_q <= 1'b0;
      resync_q <= 1'b0;
    end else if (!en) begin
      if (primed_q) resync_q <= 1'b1;
    end else if (smp_en) begin
      primed_q <= 1'b1;
      if (resync_q) begin
        hist_q   <= {HW{din}};
        lvl_q    <= din;
        resync_q <= 1'b0;
      end else begin
        hist_q <= hist_cat[HW-1:0];
        if (accept) lvl_q <= din;
      end
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = accept & din;
  assign fall_o  = accept & ~din;

  AST_TWO_SAMPLES: assert property (@(posedge clk) disable iff (rst)
    (!$stable(lvl_q) && !$past(resync_q)) |-> ($past(din) == lvl_q && $past(hist_q[0]) == lvl_q)); // R1

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
    (!fast_sel && !tick_i) |=> $stable(hist_q)); // R3

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(lvl_q) && $stable(hist_q))); // R8

endmodule

// File: rtl/pef_edge_out.sv
module pef_edge_out
  import pef_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] edge_sel,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       edge_o
);
  edge_mode_t mode;
  logic       hit;
  logic       edge_q;

  assign mode = edge_mode_t'(edge_sel);
  assign hit  = (rise_i & mode_wants_rise(mode)) | (fall_i & mode_wants_fall(mode));

  always_ff @(posedge clk) begin
    if (rst) edge_q <= 1'b0;
    else     edge_q <= hit;
  end

  assign edge_o = edge_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    edge_q |=> !edge_q); // R7

  AST_NONE_SILENT: assert property (@(posedge clk) disable iff (rst)
    ($past(edge_sel) == 2'b11) |-> !edge_q); // R5

endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLES     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       fast_sel,
  input  logic       tick_i,
  input  logic [1:0] edge_sel,
  input  logic       pin_i,
  output logic       edge_o,
  output logic       level_o
);
  logic pin_sync;
  logic rise_acc;
  logic fall_acc;

  pef_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_sync)
  );

  pef_filter #(.SAMPLES(SAMPLES)) u_filter (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .fast_sel (fast_sel),
    .tick_i   (tick_i),
    .din      (pin_sync),
    .level_o  (level_o),
    .rise_o   (rise_acc),
    .fall_o   (fall_acc)
  );

  pef_edge_out u_edge (
    .clk      (clk),
    .rst      (rst),
    .edge_sel (edge_sel),
    .rise_i   (rise_acc),
    .fall_i   (fall_acc),
    .edge_o   (edge_o)
  );

  AST_EDGE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> (level_o != $past(level_o))); // R6

  AST_RISE_MODE_DIR: assert property (@(posedge clk) disable iff (rst)
    (edge_o && $past(edge_sel) == 2'b01) |-> level_o); // R4

  AST_FALL_MODE_DIR: assert property (@(posedge clk) disable iff (rst)
    (edge_o && $past(edge_sel) == 2'b00) |-> !level_o); // R4

  AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !edge_o); // R8

endmodule

// File: tb/test_pin_edge_filter.sv
`timescale 1ns/1ps
module test_pin_edge_filter;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       fast_sel = 1'b1;
  logic       tick_i = 1'b0;
  logic [1:0] edge_sel = 2'b01;
  logic       pin_i = 1'b0;
  logic       edge_o;
  logic       level_o;

  int n_checks = 0;
  int n_fail = 0;
  int edge_cnt = 0;
  int cyc = 0;
  int tick_cnt = 0;
  bit tick_mode = 0;
  string cur_req = "R2";

  // reference model state
  int m_hist[$];
  int m_prev, m_lvl, m_edge;
  bit m_primed, m_resync;

  always #5 clk = ~clk;

  pin_edge_filter i_pin_edge_filter (
    .clk(clk), .rst(rst), .en(en), .fast_sel(fast_sel), .tick_i(tick_i),
    .edge_sel(edge_sel), .pin_i(pin_i), .edge_o(edge_o), .level_o(level_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference: pin delayed through a queue, last sample kept
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_hist = '{0, 0};
      m_prev = 0; m_lvl = 0; m_edge = 0;
      m_primed = 0; m_resync = 0;
    end else begin
      int smp;
      smp = m_hist.pop_front();
      m_hist.push_back(int'(pin_i));
      m_edge = 0;
      if (!en) begin
        if (m_primed) m_resync = 1;
      end else if (fast_sel || tick_i) begin
        if (m_resync) begin
          m_lvl = smp;
          m_resync = 0;
        end else if (smp == m_prev && smp != m_lvl) begin
          m_lvl = smp;
          if (edge_sel == 2'b10) m_edge = 1;
          else if (edge_sel == 2'b01 && smp == 1) m_edge = 1;
          else if (edge_sel == 2'b00 && smp == 0) m_edge = 1;
        end
        m_prev = smp;
        m_primed = 1;
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(int'(level_o) == m_lvl, {cur_req, " level"}, int'(level_o), m_lvl);
      check(int'(edge_o) == m_edge, {cur_req, " edge"}, int'(edge_o), m_edge);
      if (edge_o) edge_cnt++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      tick_i = tick_mode && (tick_cnt % 4 == 0);
      tick_cnt++;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R11: reset state
    step(3);
    check(level_o == 1'b0, "R11 level", int'(level_o), 0);
    check(edge_o == 1'b0, "R11 edge", int'(edge_o), 0);
    rst = 1'b0;
    step(1);
    check(level_o == 1'b0 && edge_o == 1'b0, "R11 after", int'(level_o), 0);

    // R8: pin high while disabled, nothing happens
    cur_req = "R8";
    pin_i = 1'b1;
    edge_cnt = 0;
    step(8);
    check(level_o == 1'b0, "R8 held level", int'(level_o), 0);
    check(edge_cnt == 0, "R8 no edge", edge_cnt, 0);

    // R9: first enable after reset with pin high gives one rise
    cur_req = "R9";
    edge_sel = 2'b01;
    en = 1'b1;
    edge_cnt = 0;
    step(10);
    check(edge_cnt == 1, "R9 false rise", edge_cnt, 1);
    check(level_o == 1'b1, "R9 level", int'(level_o), 1);

    // R6: latency in fast mode, falling mode
    cur_req = "R6";
    edge_sel = 2'b00;
    pin_i = 1'b0;
    step(3);
    check(level_o == 1'b1, "R6 before k+3", int'(level_o), 1);
    step(1);
    check(level_o == 1'b0, "R6 level at k+3", int'(level_o), 0);
    check(edge_o == 1'b1, "R6 edge at k+3", int'(edge_o), 1);
    step(1);
    check(edge_o == 1'b0, "R7 single pulse", int'(edge_o), 0);
    step(4);

    // R1: one-sample glitch in fast mode discarded
    cur_req = "R1";
    edge_sel = 2'b10;
    edge_cnt = 0;
    pin_i = 1'b1; step(1); pin_i = 1'b0; step(8);
    check(edge_cnt == 0 && level_o == 1'b0, "R1 glitch", edge_cnt, 0);
    pin_i = 1'b1; step(2); pin_i = 1'b0; step(8);
    check(edge_cnt == 2, "R1 two-sample pulse", edge_cnt, 2);

    // R4: direction selection
    cur_req = "R4";
    edge_sel = 2'b01; edge_cnt = 0;
    pin_i = 1'b1; step(6); pin_i = 1'b0; step(6);
    check(edge_cnt == 1, "R4 rise only", edge_cnt, 1);
    edge_sel = 2'b00; edge_cnt = 0;
    pin_i = 1'b1; step(6); pin_i = 1'b0; step(6);
    check(edge_cnt == 1, "R4 fall only", edge_cnt, 1);
    edge_sel = 2'b10; edge_cnt = 0;
    pin_i = 1'b1; step(6); pin_i = 1'b0; step(6);
    check(edge_cnt == 2, "R4 both", edge_cnt, 2);

    // R5: none mode, level still follows
    cur_req = "R5";
    edge_sel = 2'b11; edge_cnt = 0;
    pin_i = 1'b1; step(6);
    check(level_o == 1'b1, "R5 level tracks", int'(level_o), 1);
    pin_i = 1'b0; step(6);
    check(edge_cnt == 0 && level_o == 1'b0, "R5 silent", edge_cnt, 0);

    // R3: tick-driven sampling
    cur_req = "R3";
    edge_sel = 2'b10; fast_sel = 1'b0; tick_mode = 1; edge_cnt = 0;
    step(8);
    pin_i = 1'b1; step(3); pin_i = 1'b0; step(16);
    check(edge_cnt == 0 && level_o == 1'b0, "R3 short pulse", edge_cnt, 0);
    pin_i = 1'b1; step(12);
    check(level_o == 1'b1, "R3 long pulse level", int'(level_o), 1);
    pin_i = 1'b0; step(14);
    check(edge_cnt == 2, "R3 long pulse edges", edge_cnt, 2);
    tick_mode = 0; tick_i = 1'b0; fast_sel = 1'b1;

    // R10: re-enable after stop with pin high, no rise
    cur_req = "R10";
    edge_sel = 2'b01; step(4);
    en = 1'b0; step(2);
    pin_i = 1'b1; step(6);
    check(level_o == 1'b0, "R8 held across stop", int'(level_o), 0);
    edge_cnt = 0;
    en = 1'b1; step(10);
    check(edge_cnt == 0, "R10 no rise", edge_cnt, 0);
    check(level_o == 1'b1, "R10 level loaded", int'(level_o), 1);

    // R2: fast mode follows every clock after re-enable
    cur_req = "R2";
    edge_sel = 2'b10; edge_cnt = 0;
    pin_i = 1'b0; step(4);
    check(level_o == 1'b0 && edge_cnt == 1, "R2 fast fall", edge_cnt, 1);
    step(4);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule